// File: doc/BRIEF.md
# Management Serial Slave with Indirect Extended Register Access

This block is the management-side slave of a 10/100 Ethernet transceiver. It watches the management clock and data line, each brought into the local clock domain through a two-flop synchroniser. It recognises clause-22 read and write frames that carry its own 5-bit station address, which comes from a strap input; the usual strap value is 00001. Frames addressed to another station pass by without effect. A read frame is answered by driving the shared data line through an output enable. A write frame updates storage and never drives the line.

Behind the frame decoder there are two register spaces. The first is a small direct file of 16-bit registers. The second is a larger extended space, reached indirectly through two direct locations. Location 0x0D is the indirect control register. Its bits 15:14 choose an access function and its bits 4:0 name a device. Location 0x0E is the indirect window. When the function is 00, the window reaches an internal address pointer. For any other function it reaches the extended word that the pointer selects, and functions 10 and 11 advance the pointer after the access. A host writes an extended word in four steps: 0x001F to 0x0D, the word address to 0x0E, 0x401F to 0x0D, and then the data to 0x0E.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, the output enable is low and every direct register, extended word, control field and the pointer read as zero.
- R2: A frame is decoded only when at least 32 consecutive ones come before the start bits 0,1. A frame preceded by fewer ones has no effect.
- R3: During a write frame (opcode 01), the output enable is never asserted.
- R4: On a read frame (opcode 10) to the own station address, the line is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow most significant bit first, and the line is released after the last data bit. The output enable changes only just after a rising edge of the management clock.
- R5: A frame whose 5-bit station address differs from the strap input never drives the line and changes no register and no pointer.
- R6: Direct locations below the direct-file size, other than 0x0D and 0x0E, read back the last value written to them.
- R7: Location 0x0D stores bits 15:14 (function) and bits 4:0 (device). Bits 13:5 always read as zero.
- R8: With function 00, location 0x0E reads and writes the 16-bit address pointer.
- R9: With function 01, location 0x0E reads and writes the extended word at the pointer, and the pointer never changes.
- R10: With function 10, the pointer increments by one after every read and every write of location 0x0E.
- R11: With function 11, the pointer increments by one after every write of location 0x0E but not after a read.
- R12: Data access through 0x0E reaches the extended words only when the device field equals 31. For any other device the access reads zero and writes are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, much faster than the management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Value of the shared management data line |
| phy_addr | input | 5 | Strapped station address |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The assertions check the line-driving rules on every cycle. Write frames never drive the line, a mismatched header leaves it released, and the enable rises with a 0 and moves only after a clock edge. They also check the pointer discipline: the pointer stays frozen under function 01 and moves only on writes under function 11. The bench scenarios are the only place that shows the preamble length rule, the actual data order on the line, and the values returned through the indirect window. These include the pointer arithmetic under functions 10 and 11 and the device-field gating.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int DIR_NUM = 16,
  parameter int EXT_AW = 5,
  parameter int PRE_LEN = 32,
  parameter logic [4:0] EXT_DEVAD = 5'd31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  input  logic [4:0] phy_addr,
  output logic       mdio_o,
  output logic       mdio_oe
);
  localparam int EXT_NUM = 1 << EXT_AW;
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam int DA = $clog2(DIR_NUM);
  localparam logic [2:0] S_PRE = 3'd0, S_ST = 3'd1, S_HDR = 3'd2,
                         S_RTA = 3'd3, S_RD = 3'd4, S_WR = 3'd5;

  logic [2:0]    mdc_s;
  logic [1:0]    mdi_s;
  logic [2:0]    st;
  logic [PW-1:0] pre_cnt;
  logic [4:0]    cnt;
  logic [15:0]   sh, rd_sh, ptr, rdata, ext_rd;
  logic [4:0]    reg_a, devad;
  logic [1:0]    func;
  logic [15:0]   dir [DIR_NUM];
  logic [15:0]   ext [EXT_NUM];

  wire        mdc_rise   = mdc_s[1] & ~mdc_s[2];
  wire        bit_in     = mdi_s[1];
  wire [1:0]  op_n       = sh[10:9];
  wire [4:0]  ra_n       = {sh[3:0], bit_in};
  wire        addr_match = sh[8:4] == phy_addr;
  wire        hdr_done   = mdc_rise && st == S_HDR && cnt == 5'd11;
  wire        wr_apply   = mdc_rise && st == S_WR && cnt == 5'd17;
  wire        in_write   = st == S_WR;
  wire [15:0] wdata      = {sh[14:0], bit_in};
  wire        ext_hit    = devad == EXT_DEVAD && (ptr >> EXT_AW) == 16'd0;

  assign ext_rd = ext_hit ? ext[ptr[EXT_AW-1:0]] : 16'd0;

  always_comb begin
    rdata = 16'd0;
    if (ra_n == 5'd13)            rdata = {func, 9'd0, devad};
    else if (ra_n == 5'd14)       rdata = (func == 2'b00) ? ptr : ext_rd;
    else if (int'(ra_n) < DIR_NUM) rdata = dir[ra_n[DA-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_s <= '0;
      mdi_s <= '1;
    end else begin
      mdc_s <= {mdc_s[1:0], mdc};
      mdi_s <= {mdi_s[0], mdio_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PRE; pre_cnt <= '0; cnt <= '0; sh <= '0; rd_sh <= '0;
      reg_a <= '0; func <= '0; devad <= '0; ptr <= '0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
      for (int i = 0; i < DIR_NUM; i++) dir[i] <= '0;
      for (int i = 0; i < EXT_NUM; i++) ext[i] <= '0;
    end else if (mdc_rise) begin
      case (st)
        S_PRE: begin
          if (bit_in) begin
            if (pre_cnt != PW'(PRE_LEN)) pre_cnt <= pre_cnt + PW'(1);
          end else begin
            if (pre_cnt == PW'(PRE_LEN)) st <= S_ST;
            pre_cnt <= '0;
          end
        end
        S_ST: begin
          st  <= bit_in ? S_HDR : S_PRE;
          cnt <= '0;
        end
        S_HDR: begin
          sh  <= {sh[14:0], bit_in};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd11) begin
            cnt   <= '0;
            reg_a <= ra_n;
            if (addr_match && op_n == 2'b10) begin
              rd_sh <= rdata;
              st    <= S_RTA;
              if (ra_n == 5'd14 && func == 2'b10) ptr <= ptr + 16'd1;
            end else if (addr_match && op_n == 2'b01) begin
              st <= S_WR;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_RTA: begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
          cnt     <= '0;
          st      <= S_RD;
        end
        S_RD: begin
          if (cnt == 5'd16) begin
            mdio_oe <= 1'b0;
            st      <= S_PRE;
          end else begin
            mdio_o <= rd_sh[15];
            rd_sh  <= {rd_sh[14:0], 1'b0};
            cnt    <= cnt + 5'd1;
          end
        end
        S_WR: begin
          sh  <= wdata;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd17) begin
            st <= S_PRE;
            if (reg_a == 5'd13) begin
              func  <= wdata[15:14];
              devad <= wdata[4:0];
            end else if (reg_a == 5'd14) begin
              if (func == 2'b00) ptr <= wdata;
              else begin
                if (ext_hit) ext[ptr[EXT_AW-1:0]] <= wdata;
                if (func[1]) ptr <= ptr + 16'd1;
              end
            end else if (int'(reg_a) < DIR_NUM) begin
              dir[reg_a[DA-1:0]] <= wdata;
            end
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

module mdio_mgmt_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc_rise,
  input logic        mdio_oe,
  input logic        mdio_o,
  input logic        in_write,
  input logic        hdr_done,
  input logic        addr_match,
  input logic        wr_apply,
  input logic [1:0]  func,
  input logic [15:0] ptr
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mdio_oe);
  p_write_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |-> !mdio_oe);
  p_ta_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  p_oe_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe != $past(mdio_oe)) |-> $past(mdc_rise));
  p_foreign_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && !addr_match) |=> !mdio_oe);
  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ($past(func) != 2'b01));
  p_write_only_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(func) == 2'b11 && ptr != $past(ptr)) |-> $past(wr_apply));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_oe(mdio_oe),
  .mdio_o(mdio_o), .in_write(in_write), .hdr_done(hdr_done),
  .addr_match(addr_match), .wr_apply(wr_apply), .func(func), .ptr(ptr)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  localparam int HALF = 10;
  localparam logic [4:0] OWN = 5'b00001;

  logic clk = 0, rst_n = 0, mdc = 0, mst = 1;
  logic oe, dout, s_line, s_oe;
  logic oe_seen = 0;
  int checks = 0, fails = 0, cyc = 0;
  wire line = oe ? dout : mst;

  always #2 clk = ~clk;

  mdio_mgmt_slave dut (.clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .phy_addr(OWN), .mdio_o(dout), .mdio_oe(oe));

  always @(negedge clk) if (oe === 1'b1) oe_seen = 1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b);
    mst = b;
    repeat (HALF) @(negedge clk);
    s_line = line; s_oe = oe;
    mdc = 1;
    repeat (HALF) @(negedge clk);
    mdc = 0;
  endtask

  task automatic hdr(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    repeat (pre) bit_x(1);
    bit_x(0); bit_x(1); bit_x(op[1]); bit_x(op[0]);
    for (int i = 4; i >= 0; i--) bit_x(pa[i]);
    for (int i = 4; i >= 0; i--) bit_x(ra[i]);
  endtask

  task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d, input int pre = 32);
    oe_seen = 0;
    hdr(pre, 2'b01, pa, ra);
    bit_x(1); bit_x(0);
    for (int i = 15; i >= 0; i--) bit_x(d[i]);
    chk(!oe_seen, pa == OWN ? "R3 write frame left line undriven" : "R5 foreign write undriven",
        16'(oe_seen), 16'd0);
  endtask

  task automatic rd(input logic [4:0] pa, input logic [4:0] ra, output logic [15:0] d);
    logic ok;
    oe_seen = 0;
    hdr(32, 2'b10, pa, ra);
    bit_x(1); ok = !s_oe;
    bit_x(1); ok = ok && (pa == OWN ? (s_oe && !s_line) : !s_oe);
    for (int i = 15; i >= 0; i--) begin
      bit_x(1);
      d[i] = s_line;
      ok = ok && (s_oe == (pa == OWN));
    end
    bit_x(1); ok = ok && !s_oe;
    if (pa == OWN) chk(ok, "R4 turnaround and data drive timing", 16'(ok), 16'd1);
    else chk(!oe_seen, "R5 foreign read undriven", 16'(oe_seen), 16'd0);
  endtask

  task automatic rd_exp(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    logic [15:0] d;
    rd(OWN, ra, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic t_reset;
    chk(oe == 1'b0, "R1 enable low after reset", 16'(oe), 16'd0);
    rd_exp(5'd2, 16'h0000, "R1 direct reg zero");
    rd_exp(5'd13, 16'h0000, "R1 control zero");
    rd_exp(5'd14, 16'h0000, "R1 pointer zero");
  endtask

  task automatic t_direct;
    wr(OWN, 5'd2, 16'hA5C3);
    wr(OWN, 5'd7, 16'h8001);
    wr(OWN, 5'd15, 16'h1234);
    rd_exp(5'd2, 16'hA5C3, "R6 direct reg 2");
    rd_exp(5'd7, 16'h8001, "R6 direct reg 7 msb-first order");
    rd_exp(5'd15, 16'h1234, "R6 direct reg 15");
  endtask

  task automatic t_ctrl;
    wr(OWN, 5'd13, 16'hFFFF);
    rd_exp(5'd13, 16'hC01F, "R7 reserved bits read zero");
    wr(OWN, 5'd13, 16'h401F);
    rd_exp(5'd13, 16'h401F, "R7 function and device stored");
  endtask

  task automatic t_foreign;
    logic [15:0] d;
    wr(5'd2, 5'd2, 16'h0000);
    rd(5'd2, 5'd2, d);
    rd_exp(5'd2, 16'hA5C3, "R5 foreign write left reg unchanged");
  endtask

  task automatic t_short_pre;
    bit_x(0);
    wr(OWN, 5'd3, 16'h5555, 31);
    rd_exp(5'd3, 16'h0000, "R2 short preamble ignored");
  endtask

  task automatic t_addr_mode;
    wr(OWN, 5'd13, 16'h001F);
    wr(OWN, 5'd14, 16'h0005);
    rd_exp(5'd14, 16'h0005, "R8 pointer written via window");
  endtask

  task automatic t_mode01;
    wr(OWN, 5'd13, 16'h401F);
    wr(OWN, 5'd14, 16'hBEEF);
    rd_exp(5'd14, 16'hBEEF, "R9 extended word readback");
    rd_exp(5'd14, 16'hBEEF, "R9 no step after read");
    wr(OWN, 5'd13, 16'h001F);
    rd_exp(5'd14, 16'h0005, "R9 pointer unchanged");
  endtask

  task automatic t_devad;
    wr(OWN, 5'd13, 16'h4003);
    wr(OWN, 5'd14, 16'h7777);
    rd_exp(5'd14, 16'h0000, "R12 other device reads zero");
    wr(OWN, 5'd13, 16'h401F);
    rd_exp(5'd14, 16'hBEEF, "R12 write to other device dropped");
  endtask

  task automatic t_mode10;
    wr(OWN, 5'd13, 16'h001F);
    wr(OWN, 5'd14, 16'h0008);
    wr(OWN, 5'd13, 16'h801F);
    wr(OWN, 5'd14, 16'h1111);
    wr(OWN, 5'd14, 16'h2222);
    wr(OWN, 5'd13, 16'h001F);
    rd_exp(5'd14, 16'h000A, "R10 step after each write");
    wr(OWN, 5'd14, 16'h0008);
    wr(OWN, 5'd13, 16'h801F);
    rd_exp(5'd14, 16'h1111, "R10 first read");
    rd_exp(5'd14, 16'h2222, "R10 step after read");
    wr(OWN, 5'd13, 16'h001F);
    rd_exp(5'd14, 16'h000A, "R10 pointer after two reads");
  endtask

  task automatic t_mode11;
    wr(OWN, 5'd14, 16'h0014);
    wr(OWN, 5'd13, 16'hC01F);
    wr(OWN, 5'd14, 16'h3333);
    rd_exp(5'd14, 16'h0000, "R11 step after write");
    rd_exp(5'd14, 16'h0000, "R11 read at next word");
    wr(OWN, 5'd13, 16'h001F);
    rd_exp(5'd14, 16'h0015, "R11 no step after reads");
    wr(OWN, 5'd14, 16'h0014);
    wr(OWN, 5'd13, 16'h401F);
    rd_exp(5'd14, 16'h3333, "R11 word stored before step");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_direct;
    t_ctrl;
    t_foreign;
    t_short_pre;
    t_addr_mode;
    t_mode01;
    t_devad;
    t_mode10;
    t_mode11;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule